// File: doc/BRIEF.md
# Committed Main Clock Source Selector

This block picks the main clock from four incoming clocks and derives a system clock from it. Software writes the wanted source index into a pending select register over a small word-addressed register bus. The pending index has no effect on the clock until software commits it. To commit, software writes the update bit low and then writes it high. Only that rising transition copies the pending index into the active selection.

The active selection drives a glitch-free clock switch. Each candidate clock has its own enable, which is synchronized in that clock's own domain. A new source is enabled only after every other enable has dropped, and each enable changes only while its clock is low. A status bit tells software when a committed switch has fully settled.

An integer divider runs on the main clock and produces the system clock. A divide value of N from 2 to 255 gives a one-main-cycle high pulse every N cycles. A value of 1 passes the main clock through unchanged. A value of 0 holds the system clock low.

Top module: `clk_commit_sel`

## Requirements
- R1: After reset the registers read as follows: select (offset 0x0) = 0, update bit (offset 0x4) = 1, divide (offset 0x8) = 1, and the status bit (offset 0xC, bit 0) reads 1 once the switch has settled.
- R2: After reset the main clock follows `src_clk[0]`. Select value i routes `src_clk[i]`.
- R3: A write of 1 to bit 0 at offset 0x4, while that bit holds 0, copies the pending select (offset 0x0, bits 1:0) into the active selection. Writing the select register alone never changes the main clock.
- R4: Writing 0 to the update bit changes nothing on the clock outputs.
- R5: Writing 1 to the update bit while it already holds 1 does not commit the pending select.
- R6: With divide value N in 2..255, the system clock period is N main-clock periods and its high phase lasts one main cycle. With N = 1 the system clock equals the main clock.
- R7: With divide value 0 the system clock stays low.
- R8: The select field is bits 1:0 at 0x0, the update bit is bit 0 at 0x4, and the divide field is bits 7:0 at 0x8. Reads return the stored values. All other bits ignore writes and read as 0. The status word at 0xC is read-only.
- R9: At most one source enable is active at any time. The main clock never shows a high or low phase shorter than half the period of the fastest source.
- R10: The status bit reads 0 from the cycle after a commit that changes the source until the new source alone is enabled. Otherwise it reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| src_clk | input | 4 | Candidate main clock sources |
| main_clk | output | 1 | Selected main clock |
| sys_clk | output | 1 | Divided system clock |

## Verification
The hardest state to reach from the ports is the window of a switch in flight. In that window the old source has been told to stop but the new one is not yet enabled. The bench reaches it by committing switches between sources of very different speed, so the handshake crosses slow-to-fast and fast-to-slow boundaries. Meanwhile a monitor records the shortest high and low phase ever seen on the main clock. The bench also reads the status word in the cycle right after the commit to catch the not-settled state. The update-bit corners are reached by plain write sequences: 1 after 1, and 0 alone. Each sequence is followed by a period measurement that must show the old source.

// File: rtl/clk_commit_sel.sv
`timescale 1ns/1ps
module clk_commit_sel #(
  parameter int NSRC   = 4,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_clk,
  output logic              main_clk,
  output logic              sys_clk
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_UEN  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12);
  localparam logic [NSRC-1:0]   ONE    = {{(NSRC-1){1'b0}}, 1'b1};
  localparam logic [DIV_W-1:0]  D1     = DIV_W'(1);

  logic [SEL_W-1:0] pend_sel, act_sel;
  logic             uen_q;
  logic [DIV_W-1:0] div_q;
  logic [NSRC-1:0]  gate_en, en_s1, en_s2;
  logic             sw_done;

  wire wr_sel = bus_wr && (bus_addr == A_SEL);
  wire wr_uen = bus_wr && (bus_addr == A_UEN);
  wire wr_div = bus_wr && (bus_addr == A_DIV);
  wire commit = wr_uen && bus_wdata[0] && !uen_q;
  wire unused_wdata = ^bus_wdata[DATA_W-1:DIV_W];

  always_ff @(posedge bus_clk or negedge rst_n)
    if (!rst_n) begin
      pend_sel <= '0;
      act_sel  <= '0;
      uen_q    <= 1'b1;
      div_q    <= D1;
    end else begin
      if (wr_sel) pend_sel <= bus_wdata[SEL_W-1:0];
      if (wr_uen) uen_q <= bus_wdata[0];
      if (commit) act_sel <= pend_sel;
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SEL:   bus_rdata[SEL_W-1:0] = pend_sel;
      A_UEN:   bus_rdata[0] = uen_q;
      A_DIV:   bus_rdata[DIV_W-1:0] = div_q;
      A_STAT:  bus_rdata[0] = sw_done;
      default: ;
    endcase
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [1:0] req_sync;
    logic       gate_q;
    wire others = |(gate_en & ~(ONE << i));
    wire want   = (act_sel == SEL_W'(i)) && !others;

    always_ff @(posedge src_clk[i] or negedge rst_n)
      if (!rst_n) req_sync <= '0;
      else        req_sync <= {req_sync[0], want};

    always_ff @(negedge src_clk[i] or negedge rst_n)
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= req_sync[1];

    assign gate_en[i] = gate_q;
  end

  assign main_clk = |(src_clk & gate_en);

  always_ff @(posedge bus_clk or negedge rst_n)
    if (!rst_n) begin
      en_s1 <= '0;
      en_s2 <= '0;
    end else begin
      en_s1 <= gate_en;
      en_s2 <= en_s1;
    end

  assign sw_done = (en_s2 == (ONE << act_sel));

  logic [DIV_W-1:0] div_s1, div_m, cnt;
  logic             pulse;

  always_ff @(posedge main_clk or negedge rst_n)
    if (!rst_n) begin
      div_s1 <= D1;
      div_m  <= D1;
      cnt    <= '0;
      pulse  <= 1'b0;
    end else begin
      div_s1 <= div_q;
      div_m  <= div_s1;
      if (div_m <= D1 || cnt >= div_m - D1) cnt <= '0;
      else                                  cnt <= cnt + D1;
      pulse <= (div_m > D1) && (cnt == div_m - D1);
    end

  assign sys_clk = (div_m == D1) ? main_clk : pulse;

  assert_one_gate_R9: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $onehot0(gate_en));

  assert_commit_R3: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_uen && bus_wdata[0] && !uen_q) |=> (act_sel == $past(pend_sel)));

  assert_no_recommit_R5: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_uen && bus_wdata[0] && uen_q) |=> $stable(act_sel));

  assert_zero_write_R4: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_uen && !bus_wdata[0]) |=> $stable(act_sel));

  assert_busy_after_switch_R10: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (act_sel != $past(act_sel)) |-> !sw_done);

  assert_reserved_zero_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (bus_addr == A_UEN || bus_addr == A_STAT) |-> (bus_rdata[DATA_W-1:1] == '0));

  assert_div_off_R7: assert property (@(posedge main_clk) disable iff (!rst_n)
    (div_m == '0) |=> !pulse);

  assert_one_cycle_pulse_R6: assert property (@(posedge main_clk) disable iff (!rst_n)
    (div_m > D1 && pulse) |=> !pulse);
endmodule

// File: tb/clk_commit_sel_tb.sv
`timescale 1ns/1ps
module clk_commit_sel_tb;
  logic bus_clk = 0, rst_n = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic s0 = 0, s1 = 0, s2 = 0, s3 = 0;
  logic [3:0] src_clk;
  logic main_clk, sys_clk;
  int nchk = 0, nfail = 0;

  assign src_clk = {s3, s2, s1, s0};
  always #2 bus_clk = ~bus_clk;
  always #5 s0 = ~s0;
  always #7 s1 = ~s1;
  always #9 s2 = ~s2;
  always #3 s3 = ~s3;

  clk_commit_sel u_dut (.bus_clk(bus_clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_clk(src_clk), .main_clk(main_clk), .sys_clk(sys_clk));

  typedef struct { bit use_sys; real per; string tag; } exp_t;
  exp_t sbq[$];

  real last_rise = -1.0, last_fall = -1.0, min_hi = 1.0e9, min_lo = 1.0e9;
  int sys_edges = 0;
  always @(posedge main_clk) begin
    if (last_fall >= 0 && $realtime - last_fall < min_lo) min_lo = $realtime - last_fall;
    last_rise = $realtime;
  end
  always @(negedge main_clk) begin
    if (last_rise >= 0 && $realtime - last_rise < min_hi) min_hi = $realtime - last_rise;
    last_fall = $realtime;
  end
  always @(posedge sys_clk) sys_edges++;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge bus_clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] d;
    for (int k = 0; k < 2000; k++) begin
      bus_read(4'hC, d);
      if (d[0]) break;
    end
  endtask

  task automatic expect_period(bit use_sys, real per, string tag);
    exp_t it;
    it.use_sys = use_sys; it.per = per; it.tag = tag;
    sbq.push_back(it);
    while (sbq.size() != 0) @(negedge bus_clk);
  endtask

  initial begin : monitor
    exp_t it;
    real t0, t1, got;
    forever begin
      while (sbq.size() == 0) @(negedge bus_clk);
      it = sbq[0];
      if (it.use_sys) begin
        @(posedge sys_clk); t0 = $realtime;
        repeat (4) @(posedge sys_clk); t1 = $realtime;
      end else begin
        @(posedge main_clk); t0 = $realtime;
        repeat (4) @(posedge main_clk); t1 = $realtime;
      end
      got = (t1 - t0) / 4.0;
      nchk++;
      if (got - it.per > 0.01 || it.per - got > 0.01) begin
        nfail++;
        $display("FAIL %s: actual period %0.3f expected %0.3f", it.tag, got, it.per);
      end
      void'(sbq.pop_front());
    end
  end

  initial begin : watchdog
    #200000;
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin : driver
    logic [31:0] d;
    int e0;
    repeat (5) @(negedge bus_clk);
    rst_n = 1;
    bus_read(4'h0, d); check("R1 select reset", d, 32'h0);
    bus_read(4'h4, d); check("R1 update reset", d, 32'h1);
    bus_read(4'h8, d); check("R1 divide reset", d, 32'h1);
    wait_done();
    bus_read(4'hC, d); check("R1 R10 status settled", d, 32'h1);
    expect_period(0, 10.0, "R2 main from source 0");
    expect_period(1, 10.0, "R6 divide 1 passthrough");

    bus_write(4'h0, 32'h2);
    bus_read(4'h0, d); check("R8 select readback", d, 32'h2);
    repeat (30) @(negedge bus_clk);
    expect_period(0, 10.0, "R3 select alone no switch");

    bus_write(4'h4, 32'h1);
    repeat (30) @(negedge bus_clk);
    bus_read(4'hC, d); check("R5 status after 1-after-1", d, 32'h1);
    expect_period(0, 10.0, "R5 1-after-1 no commit");

    bus_write(4'h4, 32'h0);
    bus_read(4'h4, d); check("R8 update readback 0", d, 32'h0);
    repeat (30) @(negedge bus_clk);
    expect_period(0, 10.0, "R4 zero write no change");

    bus_write(4'h4, 32'h1);
    bus_read(4'hC, d); check("R10 busy after commit", d, 32'h0);
    wait_done();
    expect_period(0, 18.0, "R3 commit to source 2");

    bus_write(4'h0, 32'h3); bus_write(4'h4, 32'h0); bus_write(4'h4, 32'h1);
    wait_done();
    expect_period(0, 6.0, "R3 commit to source 3");

    bus_write(4'h0, 32'h1); bus_write(4'h4, 32'h0); bus_write(4'h4, 32'h1);
    wait_done();
    expect_period(0, 14.0, "R3 commit to source 1");

    bus_write(4'h8, 32'h4);
    bus_read(4'h8, d); check("R8 divide readback", d, 32'h4);
    repeat (40) @(negedge bus_clk);
    expect_period(1, 56.0, "R6 divide by 4");

    bus_write(4'h8, 32'h1);
    repeat (40) @(negedge bus_clk);
    expect_period(1, 14.0, "R6 divide 1 passthrough");

    bus_write(4'h8, 32'h0);
    repeat (40) @(negedge bus_clk);
    e0 = sys_edges;
    #1000;
    check("R7 divide 0 sys edges", sys_edges - e0, 0);
    check("R7 divide 0 sys level", {31'b0, sys_clk}, 32'h0);

    bus_write(4'h0, 32'hFFFF_FFFD);
    bus_read(4'h0, d); check("R8 select reserved bits", d, 32'h1);
    bus_write(4'h8, 32'h0000_01FF);
    bus_read(4'h8, d); check("R8 divide reserved bits", d, 32'hFF);
    bus_write(4'h4, 32'hFFFF_FFFE);
    bus_read(4'h4, d); check("R8 update reserved bits", d, 32'h0);
    bus_write(4'hC, 32'h0);
    bus_read(4'hC, d); check("R8 status read-only", d, 32'h1);

    nchk++;
    if (min_hi < 2.999 || min_lo < 2.999) begin
      nfail++;
      $display("FAIL R9 min phase: actual hi %0.3f lo %0.3f expected >= 3.000", min_hi, min_lo);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule